// File: doc/BRIEF.md
# Four-Channel DMA Bus Priority Arbiter

This block decides which of four DMA channels owns the shared system bus. Each channel drives a request line and a 3-bit bandwidth code. The default ranking is fixed, with channel 0 above channel 1, channel 1 above channel 2, and channel 2 above channel 3. A channel whose code is zero can move one place up, above its lower-numbered neighbour. The swap is decided for each adjacent pair, from the codes alone. Requests that arrive in the same cycle, from internal or external sources, are ranked by that same order.

The arbiter is a two-state machine. In `ARB_IDLE` it has no owner. If any request is present, the transition *claim* moves it to `ARB_OWNED` and registers a one-hot grant for the highest-ranked requester. In `ARB_OWNED` the transition *hold* keeps the grant while the owner's request stays high and its bus cycle has not ended. The transition *release* clears the grant and returns to `ARB_IDLE` when the owner's request is low or `cycle_end_i` is high. A new arbitration therefore happens one cycle after a release. Without requests, `ARB_IDLE` stays where it is through the transition *wait*.

Top module: `dma_prio_arb`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises with no request present, `grant_o` is all zero.
- R2: When every channel's code (bits [3n+2:3n] of `bwc_i` for channel n) is nonzero, the lowest-numbered requesting channel wins. Any nonzero code value ranks the same.
- R3: If channel n (n ≥ 1) has code 000 and channel n−1 has a nonzero code, channel n is ranked directly above channel n−1. It does not move above any channel numbered below n−1.
- R4: A zero code on channel 0 never changes the ranking.
- R5: When two adjacent channels both have code 000, the lower-numbered one stays above the other.
- R6: Swaps of separate adjacent pairs apply together. With channels 1 and 3 at code 000 and channels 0 and 2 nonzero, the order from highest to lowest is 1, 0, 3, 2.
- R7: Once a grant is issued, it stays on the same channel while that channel's request stays high and `cycle_end_i` is low, even if higher-ranked requests arrive.
- R8: In the cycle after the owner's request is sampled low, `grant_o` is zero. Arbitration takes place on the following edge.
- R9: When `cycle_end_i` is sampled high while a grant is held, `grant_o` is zero in the next cycle, even if the owner's request is still high. `cycle_end_i` has no effect when no grant is held.
- R10: `grant_o` is one-hot or all zero. A newly issued grant always goes to a channel that was requesting on the edge that issued it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Request from each channel, bit n = channel n |
| bwc_i | input | 12 | Bandwidth codes, channel n at bits [3n+2:3n] |
| cycle_end_i | input | 1 | The owner's bus cycle ends this cycle |
| grant_o | output | 4 | One-hot bus grant, registered |

## Verification
The state and the grant register together hold all of the arbiter's memory. A wrong state shows up within one cycle. A stuck owner keeps `grant_o` set after a release. A spurious return to idle drops the grant while the request is still held. A wrong ranking shows on the first grant after an idle cycle, as the wrong bit in `grant_o`. The scoreboard predicts every cycle's grant, so any of these faults produces a miscompare on the very next vector.

// File: rtl/dma_prio_pkg.sv
package dma_prio_pkg;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dma_prio_order.sv
// Builds the ranked slot list: slot 0 holds the highest-priority channel.
module dma_prio_order #(
    parameter int NCH    = 4,
    parameter int CODE_W = 3,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH*CODE_W-1:0] bwc_i,
    output logic [NCH*IDX_W-1:0]  slots_o
);

    logic [NCH-1:0] zero_code;
    logic [NCH-1:1] swap_up;   // channel c moves above channel c-1

    for (genvar c = 0; c < NCH; c++) begin : g_zero
        assign zero_code[c] = (bwc_i[c*CODE_W +: CODE_W] == '0);
    end

    // Two swaps never share a channel: swap_up[c] needs zero_code[c] set,
    // and swap_up[c+1] needs it clear.
    for (genvar c = 1; c < NCH; c++) begin : g_swap
        assign swap_up[c] = zero_code[c] & ~zero_code[c-1];
    end

    for (genvar s = 0; s < NCH; s++) begin : g_slot
        if (s == 0) begin : g_first
            assign slots_o[s*IDX_W +: IDX_W] =
                swap_up[1] ? IDX_W'(1) : IDX_W'(0);
        end else if (s == NCH - 1) begin : g_last
            assign slots_o[s*IDX_W +: IDX_W] =
                swap_up[s] ? IDX_W'(s - 1) : IDX_W'(s);
        end else begin : g_mid
            assign slots_o[s*IDX_W +: IDX_W] =
                swap_up[s]   ? IDX_W'(s - 1) :
                swap_up[s+1] ? IDX_W'(s + 1) : IDX_W'(s);
        end
    end

endmodule

// File: rtl/dma_prio_pick.sv
// Walks the ranked slots and marks the first requesting channel.
module dma_prio_pick #(
    parameter int NCH    = 4,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]       req_i,
    input  logic [NCH*IDX_W-1:0] slots_i,
    output logic [NCH-1:0]       win_o
);

    always_comb begin
        logic found;
        logic [IDX_W-1:0] ch;
        win_o = '0;
        found = 1'b0;
        for (int s = 0; s < NCH; s++) begin
            ch = slots_i[s*IDX_W +: IDX_W];
            if (!found && req_i[ch]) begin
                win_o[ch] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_prio_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 3,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NCH-1:0]        req_i,
    input  logic [NCH*CODE_W-1:0] bwc_i,
    input  logic                  cycle_end_i,
    output logic [NCH-1:0]        grant_o
);

    arb_state_e           state_q, state_d;
    logic [NCH-1:0]       grant_q, grant_d;
    logic [NCH*IDX_W-1:0] slots;
    logic [NCH-1:0]       winner;

    dma_prio_order #(.NCH(NCH), .CODE_W(CODE_W)) order_i (
        .bwc_i   (bwc_i),
        .slots_o (slots)
    );

    dma_prio_pick #(.NCH(NCH)) pick_i (
        .req_i   (req_i),
        .slots_i (slots),
        .win_o   (winner)
    );

    // State and grant registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    // Transitions: wait, claim, hold, release
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|req_i) begin
                    state_d = ARB_OWNED;
                    grant_d = winner;
                end
            end
            ARB_OWNED: begin
                if (cycle_end_i || !(|(req_i & grant_q))) begin
                    state_d = ARB_IDLE;
                    grant_d = '0;
                end
            end
            default: begin
                state_d = ARB_IDLE;
                grant_d = '0;
            end
        endcase
    end

    assign grant_o = grant_q;

    // R10
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));

    // R10
    new_grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o == '0) |=> (grant_o == '0) || ((grant_o & $past(req_i)) != '0));

    // R7
    grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((grant_o != '0) && ((req_i & grant_o) != '0) && !cycle_end_i)
        |=> (grant_o == $past(grant_o)));

    // R8
    req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((grant_o != '0) && ((req_i & grant_o) == '0)) |=> (grant_o == '0));

    // R9
    cycle_end_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((grant_o != '0) && cycle_end_i) |=> (grant_o == '0));

endmodule

// File: tb/dma_prio_arb_tb_top.sv
module dma_prio_arb_tb_top;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  req_i = '0;
    logic [11:0] bwc_i = '0;
    logic        cycle_end_i = 1'b0;
    logic [3:0]  grant_o;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];

    // bench model state
    bit       m_busy = 1'b0;
    int       m_own  = 0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    dma_prio_arb dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req_i),
        .bwc_i       (bwc_i),
        .cycle_end_i (cycle_end_i),
        .grant_o     (grant_o)
    );

    function automatic int rank_of(int c, logic [11:0] codes);
        bit z[4];
        for (int k = 0; k < 4; k++) z[k] = (codes[k*3 +: 3] == 3'b000);
        if (c > 0 && z[c] && !z[c-1]) return c - 1;
        if (c < 3 && z[c+1] && !z[c]) return c + 1;
        return c;
    endfunction

    function automatic int pick(logic [3:0] req, logic [11:0] codes);
        int best = -1;
        int best_rank = 99;
        for (int c = 0; c < 4; c++) begin
            if (req[c] && rank_of(c, codes) < best_rank) begin
                best = c;
                best_rank = rank_of(c, codes);
            end
        end
        return best;
    endfunction

    task automatic apply(input logic rst, input logic [3:0] req,
                         input logic [11:0] codes, input logic cend,
                         input string tag);
        item_t it;
        @(negedge clk_i);
        rst_ni = rst;
        req_i = req;
        bwc_i = codes;
        cycle_end_i = cend;
        if (!rst) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            if (cend || !req[m_own]) m_busy = 1'b0;
        end else if (req != 4'b0000) begin
            m_own  = pick(req, codes);
            m_busy = 1'b1;
        end
        it.exp = m_busy ? (4'b0001 << m_own) : 4'b0000;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk_i);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (grant_o !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: grant_o=%b expected %b", it.tag, grant_o, it.exp);
                end
                n_vec++;
                if ($countones(grant_o) > 1) begin
                    n_bad++;
                    $display("FAIL R10: grant_o=%b expected one-hot or zero", grant_o);
                end
            end
        end
    end

    localparam logic [11:0] ALL_NZ = {3'd7, 3'd5, 3'd2, 3'd1};
    localparam logic [11:0] Z3     = {3'd0, 3'd5, 3'd2, 3'd1};
    localparam logic [11:0] Z0     = {3'd4, 3'd5, 3'd2, 3'd0};
    localparam logic [11:0] Z12    = {3'd4, 3'd0, 3'd0, 3'd6};
    localparam logic [11:0] Z01    = {3'd4, 3'd3, 3'd0, 3'd0};
    localparam logic [11:0] Z13    = {3'd0, 3'd2, 3'd0, 3'd3};

    task automatic once(input logic [3:0] req, input logic [11:0] codes, input string tag);
        apply(1'b1, req, codes, 1'b0, tag);
        apply(1'b1, 4'b0000, codes, 1'b0, tag);
    endtask

    initial begin
        // R1: reset holds grant at zero despite requests
        apply(1'b0, 4'b1111, ALL_NZ, 1'b0, "R1");
        apply(1'b0, 4'b1111, ALL_NZ, 1'b0, "R1");
        apply(1'b1, 4'b0000, ALL_NZ, 1'b0, "R1");
        // R2: default ascending, nonzero code values equivalent
        once(4'b1111, ALL_NZ, "R2");
        once(4'b1110, ALL_NZ, "R2");
        once(4'b1100, ALL_NZ, "R2");
        once(4'b1000, ALL_NZ, "R2");
        // R3: channel 3 above 2 only
        once(4'b1100, Z3, "R3");
        once(4'b1010, Z3, "R3");
        // R4: channel 0 zero code no effect
        once(4'b0011, Z0, "R4");
        // R5: adjacent zero codes keep order
        once(4'b0110, Z12, "R5");
        once(4'b0011, Z12, "R5");
        once(4'b0011, Z01, "R5");
        // R6: order 1,0,3,2
        once(4'b1111, Z13, "R6");
        once(4'b1101, Z13, "R6");
        once(4'b1100, Z13, "R6");
        once(4'b0100, Z13, "R6");
        // R7: hold against higher-ranked arrivals
        apply(1'b1, 4'b0100, ALL_NZ, 1'b0, "R7");
        apply(1'b1, 4'b0111, ALL_NZ, 1'b0, "R7");
        apply(1'b1, 4'b0111, ALL_NZ, 1'b0, "R7");
        apply(1'b1, 4'b0111, ALL_NZ, 1'b0, "R7");
        // R8: owner drops, zero then re-arbitrate
        apply(1'b1, 4'b0011, ALL_NZ, 1'b0, "R8");
        apply(1'b1, 4'b0011, ALL_NZ, 1'b0, "R8");
        apply(1'b1, 4'b0011, ALL_NZ, 1'b0, "R8");
        apply(1'b1, 4'b0000, ALL_NZ, 1'b0, "R8");
        // R9: cycle end ignored when idle, releases when owned
        apply(1'b1, 4'b0000, ALL_NZ, 1'b1, "R9");
        apply(1'b1, 4'b1000, ALL_NZ, 1'b0, "R9");
        apply(1'b1, 4'b1000, ALL_NZ, 1'b1, "R9");
        apply(1'b1, 4'b1000, ALL_NZ, 1'b0, "R9");
        apply(1'b1, 4'b0000, ALL_NZ, 1'b0, "R9");
        // R10 / R1: reset mid-grant clears it
        apply(1'b1, 4'b0010, Z13, 1'b0, "R10");
        apply(1'b0, 4'b0010, Z13, 1'b0, "R1");
        apply(1'b1, 4'b0000, Z13, 1'b0, "R1");
        repeat (3) @(negedge clk_i);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk_i);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule